// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the data-movement core of a single DMA channel. A host loads it, while it sits idle, with a page number, a starting offset inside that page, a transfer count written as "units minus one", and a unit width (byte or 16-bit word). Loading arms the channel. From then on, a peripheral raises its request line. Each time the request meets a bus grant, the engine answers with a one-cycle acknowledge pulse and presents the memory address for that unit.

After each acknowledged unit the offset steps by one and the remaining count drops by one. The page never changes, so a run that passes the end of its page wraps back to the start of the same page. On the final unit the terminal-count flag rises in the same cycle as the acknowledge. The channel then disarms itself and ignores requests until the host loads it again.

In word mode the offset is moved one place left on the address bus. Address bit 0 therefore stays zero, and each step advances the byte address by two.

Top module: `dma_chan_engine`

## Requirements
- R1: In byte mode (cfg_wide = 0), addr during an acknowledge equals {page, offset}, with page in bits 23:16 and offset in bits 15:0.
- R2: In word mode (cfg_wide = 1), addr during an acknowledge equals {page[7:1], offset, 1'b0}: page bit 0 is ignored and addr bit 0 is 0.
- R3: After every acknowledged unit the offset increases by one modulo 65536, so the address wraps inside its page and the page bits never change.
- R4: A programmed length L yields exactly L+1 acknowledged units: L = 0 gives one unit and L = 0xFFFF gives 65536 units.
- R5: dack rises only in the cycle after one in which the channel was armed and both dreq and grant were high. Each pulse lasts one cycle and is followed by at least one low cycle.
- R6: tc is high only together with dack, and only on the final unit of a run.
- R7: After the final unit busy goes low, and dreq produces no dack until the channel is loaded again.
- R8: A cfg_we pulse while busy is high has no effect: the next unit continues with the previous page, offset and count.
- R9: Reset leaves dack, tc and busy low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Load strobe for the configuration fields; arms the channel when idle |
| cfg_page | input | 8 | Page number (fixed high address bits) |
| cfg_offset | input | 16 | Starting offset inside the page |
| cfg_len | input | 16 | Transfer units minus one |
| cfg_wide | input | 1 | 0 = byte units, 1 = 16-bit units |
| dreq | input | 1 | Transfer request from the peripheral |
| grant | input | 1 | Bus grant; a unit may start only while high |
| dack | output | 1 | One-cycle transfer acknowledge |
| tc | output | 1 | Terminal count, high with dack on the last unit |
| addr | output | 24 | Memory address for the current unit |
| busy | output | 1 | Channel armed |

## Verification
The bench builds the engine with its default widths: an 8-bit page and a 16-bit offset and count. At these widths a full 65536-unit run finishes in about 131,000 cycles. That keeps the largest length code, the end-of-count flag on the very last unit and the offset wrap from 0xFFFF to 0 within reach, in both byte and word address layouts.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic {
        UNIT_BYTE = 1'b0,
        UNIT_WORD = 1'b1
    } unit_width_e;

endpackage

// File: rtl/dma_ofs_step.sv
// Next offset / remaining count and end-of-run detection.
module dma_ofs_step #(
    parameter int OFS_W = 16
) (
    input  logic [OFS_W-1:0] ofs,
    input  logic [OFS_W-1:0] cnt,
    output logic [OFS_W-1:0] ofs_nxt,
    output logic [OFS_W-1:0] cnt_nxt,
    output logic             last
);
    localparam logic [OFS_W-1:0] ONE = OFS_W'(1);

    always_comb begin
        ofs_nxt = ofs + ONE;      // wraps inside the page, no carry out
        cnt_nxt = cnt - ONE;
        last    = (cnt == '0);
    end
endmodule

// File: rtl/dma_addr_map.sv
// Places page and offset on the address bus for byte or word units.
module dma_addr_map
    import dma_chan_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = PAGE_W + OFS_W
) (
    input  logic [PAGE_W-1:0] page,
    input  logic [OFS_W-1:0]  ofs,
    input  unit_width_e       width,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] byte_addr;
    logic [ADDR_W-1:0] word_addr;

    always_comb begin
        byte_addr = {page, ofs};
        word_addr = {page[PAGE_W-1:1], ofs, 1'b0};
        addr      = (width == UNIT_WORD) ? word_addr : byte_addr;
    end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = PAGE_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [PAGE_W-1:0] cfg_page,
    input  logic [OFS_W-1:0]  cfg_offset,
    input  logic [OFS_W-1:0]  cfg_len,
    input  logic              cfg_wide,
    input  logic              dreq,
    input  logic              grant,
    output logic              dack,
    output logic              tc,
    output logic [ADDR_W-1:0] addr,
    output logic              busy
);
    typedef struct packed {
        logic              armed;
        unit_width_e       width;
        logic              ack;
        logic [PAGE_W-1:0] page;
        logic [OFS_W-1:0]  ofs;
        logic [OFS_W-1:0]  cnt;
    } chan_state_t;

    chan_state_t st_d, st_q;

    logic [OFS_W-1:0] ofs_nxt;
    logic [OFS_W-1:0] cnt_nxt;
    logic             last_unit;
    logic             wide_q;

    dma_ofs_step #(.OFS_W(OFS_W)) i_step (
        .ofs     (st_q.ofs),
        .cnt     (st_q.cnt),
        .ofs_nxt (ofs_nxt),
        .cnt_nxt (cnt_nxt),
        .last    (last_unit)
    );

    dma_addr_map #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) i_map (
        .page  (st_q.page),
        .ofs   (st_q.ofs),
        .width (st_q.width),
        .addr  (addr)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ack = 1'b0;
        if (!st_q.armed) begin
            if (cfg_we) begin
                st_d.armed = 1'b1;
                st_d.width = cfg_wide ? UNIT_WORD : UNIT_BYTE;
                st_d.page  = cfg_page;
                st_d.ofs   = cfg_offset;
                st_d.cnt   = cfg_len;
            end
        end else if (st_q.ack) begin
            // unit completed: step the offset and count
            st_d.ofs = ofs_nxt;
            st_d.cnt = cnt_nxt;
            if (last_unit) begin
                st_d.armed = 1'b0;
            end
        end else if (dreq && grant) begin
            st_d.ack = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dack   = st_q.ack;
    assign tc     = st_q.ack & last_unit;
    assign busy   = st_q.armed;
    assign wide_q = (st_q.width == UNIT_WORD);
endmodule

// File: rtl/dma_chan_checker.sv
module dma_chan_checker #(
    parameter int PAGE_W = 8,
    parameter int OFS_W  = 16,
    localparam int ADDR_W = PAGE_W + OFS_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dreq,
    input logic              grant,
    input logic              dack,
    input logic              tc,
    input logic              busy,
    input logic              wide,
    input logic [ADDR_W-1:0] addr
);
    // R6
    a_r6_tc_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> dack);

    // R5
    a_r5_ack_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dack) |-> $past(dreq && grant && busy));

    // R5
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        dack |=> !dack);

    // R7
    a_r7_tc_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        tc |=> !busy);

    // R7
    a_r7_idle_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !dack);

    // R3
    a_r3_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> addr[ADDR_W-1:OFS_W+1] == $past(addr[ADDR_W-1:OFS_W+1]));

    // R2
    a_r2_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        (dack && wide) |-> !addr[0]);
endmodule

bind dma_chan_engine dma_chan_checker #(.PAGE_W(PAGE_W), .OFS_W(OFS_W)) i_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .dreq  (dreq),
    .grant (grant),
    .dack  (dack),
    .tc    (tc),
    .busy  (busy),
    .wide  (wide_q),
    .addr  (addr)
);

// File: tb/test_dma_chan_engine.sv
module test_dma_chan_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_page = '0;
    logic [15:0] cfg_offset = '0;
    logic [15:0] cfg_len = '0;
    logic        cfg_wide = 1'b0;
    logic        dreq = 1'b0;
    logic        grant = 1'b0;
    logic        dack;
    logic        tc;
    logic [23:0] addr;
    logic        busy;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dma_chan_engine i_dma_chan_engine (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_page(cfg_page),
        .cfg_offset(cfg_offset), .cfg_len(cfg_len), .cfg_wide(cfg_wide),
        .dreq(dreq), .grant(grant), .dack(dack), .tc(tc), .addr(addr), .busy(busy)
    );

    // vectors: page, offset, length, wide, first addr, last addr
    localparam int NV = 5;
    localparam logic [7:0]  V_PAGE [NV] = '{8'h0C, 8'h12, 8'h35, 8'hFF, 8'h00};
    localparam logic [15:0] V_OFS  [NV] = '{16'h0010, 16'hFFFF, 16'h8000, 16'hFFFF, 16'h1234};
    localparam logic [15:0] V_LEN  [NV] = '{16'd2, 16'd1, 16'd2, 16'd1, 16'd0};
    localparam logic        V_WIDE [NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0};
    localparam logic [23:0] V_A0   [NV] = '{24'h0C0010, 24'h12FFFF, 24'h350000, 24'hFFFFFE, 24'h001234};
    localparam logic [23:0] V_AN   [NV] = '{24'h0C0012, 24'h120000, 24'h350004, 24'hFE0000, 24'h001234};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] p, input logic [15:0] o, input logic [15:0] l, input logic w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_page = p; cfg_offset = o; cfg_len = l; cfg_wide = w;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // one unit: request held, ack seen after one edge, released after the next
    task automatic xfer(output logic a, output logic t, output logic [23:0] ad);
        dreq = 1'b1; grant = 1'b1;
        @(posedge clk); @(negedge clk);
        a = dack; t = tc; ad = addr;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic a, t;
        logic [23:0] ad;
        logic early_tc;
        int n_ack;

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 dack after reset", dack, 0);
        chk("R9 tc after reset", tc, 0);
        chk("R9 busy after reset", busy, 0);
        rst_n = 1'b1;

        // vector table: R1 R2 R3 R4 R6 R7
        for (int v = 0; v < NV; v++) begin
            load(V_PAGE[v], V_OFS[v], V_LEN[v], V_WIDE[v]);
            chk("R7 armed after load", busy, 1);
            for (int k = 0; k <= int'(V_LEN[v]); k++) begin
                xfer(a, t, ad);
                chk("R5 ack per unit", a, 1);
                chk("R6 tc only on last", t, (k == int'(V_LEN[v])) ? 1 : 0);
                if (k == 0) chk(V_WIDE[v] ? "R2 first addr" : "R1 first addr", ad, V_A0[v]);
                if (k == int'(V_LEN[v])) chk("R3 R4 last addr", ad, V_AN[v]);
            end
            chk("R7 disarmed after tc", busy, 0);
            n_ack = 0;
            repeat (4) begin
                @(posedge clk); @(negedge clk);
                if (dack) n_ack++;
            end
            chk("R7 dreq ignored when idle", n_ack, 0);
            dreq = 1'b0;
        end

        // grant gating: R5
        load(8'h20, 16'h0000, 16'd0, 1'b0);
        dreq = 1'b1; grant = 1'b0;
        n_ack = 0;
        repeat (4) begin
            @(posedge clk); @(negedge clk);
            if (dack) n_ack++;
        end
        chk("R5 no ack without grant", n_ack, 0);
        grant = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R5 ack once granted", dack, 1);
        chk("R1 addr when granted", addr, 24'h200000);
        @(posedge clk); @(negedge clk);
        dreq = 1'b0;

        // config write while busy: R8
        load(8'h01, 16'h0100, 16'd3, 1'b0);
        xfer(a, t, ad);
        chk("R1 first busy unit", ad, 24'h010100);
        dreq = 1'b0;
        @(negedge clk);
        cfg_we = 1'b1; cfg_page = 8'h02; cfg_offset = 16'h0000; cfg_len = 16'd0; cfg_wide = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
        xfer(a, t, ad);
        chk("R8 write ignored addr", ad, 24'h010101);
        chk("R8 write ignored tc", t, 0);

        // reset while armed: R9
        dreq = 1'b1; grant = 1'b1;
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R9 busy cleared by reset", busy, 0);
        chk("R9 dack low in reset", dack, 0);
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R9 no ack after reset", dack, 0);
        dreq = 1'b0;

        // full 65536-unit run: R4 R6
        load(8'h40, 16'h0000, 16'hFFFF, 1'b0);
        early_tc = 1'b0;
        n_ack = 0;
        dreq = 1'b1; grant = 1'b1;
        for (int i = 0; i < 65536; i++) begin
            @(posedge clk); @(negedge clk);
            if (dack) n_ack++;
            if (tc && i != 65535) early_tc = 1'b1;
            if (i == 65535) begin
                chk("R6 tc on unit 65536", tc, 1);
                chk("R3 wrap-end addr", addr, 24'h40FFFF);
            end
            @(posedge clk); @(negedge clk);
        end
        chk("R4 65536 acks", n_ack, 65536);
        chk("R6 no early tc", early_tc, 0);
        chk("R7 idle after long run", busy, 0);
        dreq = 1'b0;

        finish_run();
    end
endmodule